// File: doc/BRIEF.md
# Table-Driven PWM Sine Synthesizer

This block plays a stored list of duty samples on one PWM pin. Each sample is held for exactly one PWM period, and then the next sample takes over on its own. After an external RC low-pass filter, the pin therefore traces the stored waveform. The waveform repeats at the PWM period rate divided by the number of table steps. For example, a counter top of 40 on a 16 MHz tick gives 400 kHz. With 40 steps that yields a 10 kHz tone, and with 80 steps a 5 kHz tone.

The counter tick comes from the input clock divided by a power of two chosen with `presc_sel`. Two table layouts are offered:
- **Shared-period layout:** one word per step holds the duty, and the period top comes from the `base_top` input.
- **Per-step layout:** four words per step. The first word holds the duty and the fourth holds that step's period top. The middle two words are unused.

The counter runs either up-only or up-then-down (centre-aligned). The table is loaded through a plain write port while the player is idle. A one-cycle `seq_end` pulse marks the end of each pass. With `loop_en` high, playback wraps back to step 0 without a gap.

Top module: `tone_pwm_player`

## Requirements
- R1: After reset and whenever no sequence is playing, `pwm_out` and `seq_end` are 0.
- R2: The counter advances once every 2^`presc_sel` clock cycles, so every period and every high time scales by that factor.
- R3: In up mode (`updown`=0) one period lasts `top` ticks. The pin is high while the counter (0 to top-1) is below the duty, which is the first `duty` ticks of the period.
- R4: In up/down mode (`updown`=1) the counter runs 0 to top-1 and then top-1 down to 0. The period is 2*top ticks and the pin is high for 2*duty ticks, centred on the period edges.
- R5: A duty of 0 keeps the pin low for the whole period. A duty equal to or above the top keeps it high for the whole period.
- R6: With `wave_mode`=0, step k takes its duty from word k and its period top from `base_top`. A top value of 0 is treated as 1.
- R7: With `wave_mode`=1, step k takes its duty from word 4k and its top from word 4k+3. Words 4k+1 and 4k+2 have no effect on the output.
- R8: Steps 0 to `last_step` are played in order, one per period. A pass lasts the sum of their periods, which sets the synthesized waveform frequency.
- R9: Duty and top are taken only at a period boundary. A change of `base_top` in the middle of a period does not alter that period.
- R10: `seq_end` is high for exactly the one cycle that follows the end of the last step's period.
- R11: With `loop_en`=1 at the end of the last step, step 0 starts in the very next cycle with no gap. With `loop_en`=0 at that moment, playback stops and the pin stays low.
- R12: A `start` pulse while idle begins step 0 from the next cycle. A `start` pulse while playing is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| presc_sel | input | SEL_W | Tick divider exponent: tick every 2^presc_sel clocks |
| updown | input | 1 | 0 = up counting, 1 = up/down counting |
| wave_mode | input | 1 | 0 = one word per step, 1 = four words per step with per-step top |
| loop_en | input | 1 | Wrap to step 0 after the last step |
| start | input | 1 | Begin playback when idle |
| base_top | input | DATA_W | Period top used in the one-word layout |
| last_step | input | ADDR_W | Index of the final step |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | ADDR_W | Table word address |
| wr_data | input | DATA_W | Table word data |
| pwm_out | output | 1 | PWM output pin |
| seq_end | output | 1 | One-cycle end-of-pass pulse |

## Verification
Two events can land on the same clock edge. The first is the end of the last step's period, which raises `seq_end`. The second is the reload of step 0 when looping is enabled. The bench provokes this with a two-step looping table. It counts cycles and high samples from one `seq_end` to the next, starting with the `seq_end` cycle itself. A pass of exactly the summed period length, whose first cycle already shows step 0's duty, proves there is no gap and no lost sample. A `start` pulse injected mid-pass must leave the pass length unchanged. Dropping `loop_en` during a pass must end playback after that pass.

// File: rtl/tpp_pkg.sv
// Shared definitions for the table-driven PWM player.
package tpp_pkg;
    // Counting direction inside a centre-aligned period.
    typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} cnt_dir_e;
    // Per-step layout: four words per step, top sits in the last slot.
    localparam int STEP_SHIFT = 2;
    localparam int TOP_SLOT   = 3;
endpackage

// File: rtl/tpp_tick_div.sv
// Power-of-two tick divider.
// Emits tick once every 2^sel enabled cycles; clr restarts the phase so the
// first tick after clr comes 2^sel cycles later. Assumes sel is static while en.
module tpp_tick_div #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int DIV_W = (1 << SEL_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    // Low sel bits of the phase counter all ones marks a tick.
    always_comb begin
        mask = ~({DIV_W{1'b1}} << sel);
        tick = en & (&(div_q | ~mask));
    end

    // Free-running phase counter, cleared on playback start.
    always_ff @(posedge clk) begin
        if (!rst_n)      div_q <= '0;
        else if (clr)    div_q <= '0;
        else if (en)     div_q <= div_q + 1'b1;
    end
endmodule

// File: rtl/tpp_seq_ram.sv
// Sample table: one write port, two asynchronous read ports (duty and top).
// Assumes writes happen while the player is idle; contents are not reset.
module tpp_seq_ram #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_a_addr,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [ADDR_W-1:0] rd_b_addr,
    output logic [DATA_W-1:0] rd_b_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Store one word per write strobe.
    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_addr] <= wr_data;
    end

    // Look-ahead reads for the step about to be latched.
    always_comb begin
        rd_a_data = mem_q[rd_a_addr];
        rd_b_data = mem_q[rd_b_addr];
    end
endmodule

// File: rtl/tpp_wave_counter.sv
// PWM period counter, up-only or up/down.
// Up: 0..top-1 then wrap. Up/down: 0..top-1, then top-1..0 (2*top ticks).
// period_end flags the tick that closes a period. Assumes top >= 1 and that
// top changes only at a period boundary.
module tpp_wave_counter
    import tpp_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic              tick,
    input  logic              updown,
    input  logic [DATA_W-1:0] top,
    output logic [DATA_W-1:0] cnt_q,
    output logic              period_end
);
    cnt_dir_e dir_q;
    logic     last_up;

    // Detect the turning point and the closing tick of a period.
    always_comb begin
        last_up    = (cnt_q == top - DATA_W'(1));
        period_end = en & tick &
                     (updown ? ((dir_q == DIR_DOWN) && (cnt_q == '0)) : last_up);
    end

    // Step the counter and direction on each enabled tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
            dir_q <= DIR_UP;
        end else if (en && tick) begin
            if (period_end) begin
                cnt_q <= '0;
                dir_q <= DIR_UP;
            end else if (updown && dir_q == DIR_UP && last_up) begin
                dir_q <= DIR_DOWN;
            end else if (updown && dir_q == DIR_DOWN) begin
                cnt_q <= cnt_q - DATA_W'(1);
            end else begin
                cnt_q <= cnt_q + DATA_W'(1);
            end
        end
    end
endmodule

// File: rtl/tpp_step_ctrl.sv
// Step sequencer: holds the active step index, latches duty and top for the
// next step at each period boundary, wraps or stops after the last step and
// raises a one-cycle end pulse. Assumes table reads are combinational.
module tpp_step_ctrl
    import tpp_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              loop_en,
    input  logic              wave_mode,
    input  logic [ADDR_W-1:0] last_step,
    input  logic [DATA_W-1:0] base_top,
    input  logic              period_end,
    input  logic [DATA_W-1:0] duty_word,
    input  logic [DATA_W-1:0] top_word,
    output logic [ADDR_W-1:0] duty_addr,
    output logic [ADDR_W-1:0] top_addr,
    output logic              start_ok,
    output logic              run_q,
    output logic [DATA_W-1:0] duty_q,
    output logic [DATA_W-1:0] top_q,
    output logic              seq_end
);
    logic [ADDR_W-1:0] idx_q;
    logic [ADDR_W-1:0] next_idx;
    logic [ADDR_W-1:0] wave_base;
    logic [DATA_W-1:0] top_raw;
    logic [DATA_W-1:0] top_new;
    logic              at_last;

    // Choose the next step and form its table addresses and top.
    always_comb begin
        start_ok  = start & ~run_q;
        at_last   = (idx_q == last_step);
        next_idx  = (start_ok || at_last) ? '0 : idx_q + ADDR_W'(1);
        wave_base = next_idx << STEP_SHIFT;
        duty_addr = wave_mode ? wave_base : next_idx;
        top_addr  = wave_base | ADDR_W'(TOP_SLOT);
        top_raw   = wave_mode ? top_word : base_top;
        top_new   = (top_raw == '0) ? DATA_W'(1) : top_raw;
    end

    // Start, advance, wrap or stop at period boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            idx_q   <= '0;
            duty_q  <= '0;
            top_q   <= DATA_W'(1);
            seq_end <= 1'b0;
        end else begin
            seq_end <= 1'b0;
            if (start_ok) begin
                run_q  <= 1'b1;
                idx_q  <= '0;
                duty_q <= duty_word;
                top_q  <= top_new;
            end else if (run_q && period_end) begin
                seq_end <= at_last;
                if (at_last && !loop_en) begin
                    run_q  <= 1'b0;
                    duty_q <= '0;
                end else begin
                    idx_q  <= next_idx;
                    duty_q <= duty_word;
                    top_q  <= top_new;
                end
            end
        end
    end
endmodule

// File: rtl/tone_pwm_player.sv
// Table-driven PWM player: one duty sample per PWM period, auto-advancing,
// with optional per-step period top and looping. Output is high while the
// period counter is below the latched duty. Table writes are expected only
// while idle.
module tone_pwm_player #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 6,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  presc_sel,
    input  logic              updown,
    input  logic              wave_mode,
    input  logic              loop_en,
    input  logic              start,
    input  logic [DATA_W-1:0] base_top,
    input  logic [ADDR_W-1:0] last_step,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              pwm_out,
    output logic              seq_end
);
    logic              tick;
    logic              start_ok;
    logic              run_q;
    logic              period_end;
    logic [DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0] duty_q;
    logic [DATA_W-1:0] top_q;
    logic [ADDR_W-1:0] duty_addr;
    logic [ADDR_W-1:0] top_addr;
    logic [DATA_W-1:0] duty_word;
    logic [DATA_W-1:0] top_word;

    tpp_tick_div #(.SEL_W(SEL_W)) u_div (
        .clk(clk), .rst_n(rst_n), .clr(start_ok), .en(run_q),
        .sel(presc_sel), .tick(tick)
    );

    tpp_seq_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_a_addr(duty_addr), .rd_a_data(duty_word),
        .rd_b_addr(top_addr),  .rd_b_data(top_word)
    );

    tpp_wave_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(start_ok), .en(run_q), .tick(tick),
        .updown(updown), .top(top_q), .cnt_q(cnt_q), .period_end(period_end)
    );

    tpp_step_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .loop_en(loop_en),
        .wave_mode(wave_mode), .last_step(last_step), .base_top(base_top),
        .period_end(period_end), .duty_word(duty_word), .top_word(top_word),
        .duty_addr(duty_addr), .top_addr(top_addr), .start_ok(start_ok),
        .run_q(run_q), .duty_q(duty_q), .top_q(top_q), .seq_end(seq_end)
    );

    // Compare stage: high while the counter sits below the duty.
    always_comb pwm_out = run_q & (cnt_q < duty_q);
endmodule

// File: rtl/tpp_checker.sv
// Temporal checks on the PWM player, attached by bind.
module tpp_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_q,
    input logic              pwm_out,
    input logic              seq_end,
    input logic              period_end,
    input logic [DATA_W-1:0] cnt_q,
    input logic [DATA_W-1:0] duty_q,
    input logic [DATA_W-1:0] top_q
);
    // R1
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> !pwm_out);

    // R10
    end_follows_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_end |-> ($past(run_q) && $past(period_end)));

    // R9
    hold_mid_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(run_q) && !$past(period_end)) |->
        ($stable(duty_q) && $stable(top_q)));

    // R3
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (cnt_q < top_q));

    // R5
    zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && duty_q == '0) |-> !pwm_out);

    // R5
    full_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && duty_q >= top_q) |-> pwm_out);
endmodule

bind tone_pwm_player tpp_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run_q(run_q), .pwm_out(pwm_out),
    .seq_end(seq_end), .period_end(period_end), .cnt_q(cnt_q),
    .duty_q(duty_q), .top_q(top_q)
);

// File: tb/tone_pwm_player_tb.sv
module tone_pwm_player_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  presc_sel = '0;
    logic        updown = 1'b0;
    logic        wave_mode = 1'b0;
    logic        loop_en = 1'b0;
    logic        start = 1'b0;
    logic [15:0] base_top = 16'd1;
    logic [5:0]  last_step = '0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        pwm_out;
    logic        seq_end;

    int checks = 0;
    int errors = 0;

    tone_pwm_player u_dut (
        .clk(clk), .rst_n(rst_n), .presc_sel(presc_sel), .updown(updown),
        .wave_mode(wave_mode), .loop_en(loop_en), .start(start),
        .base_top(base_top), .last_step(last_step), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out),
        .seq_end(seq_end)
    );

    always #4 clk = ~clk;

    // {presc_sel, updown, top, duty}
    localparam int NV = 10;
    localparam int VEC [NV][4] = '{
        '{0, 0, 10, 3}, '{1, 0, 8, 5}, '{2, 0, 5, 2}, '{0, 1, 6, 2},
        '{1, 1, 4, 3},  '{0, 0, 7, 0}, '{0, 0, 7, 7}, '{0, 0, 6, 9},
        '{3, 1, 3, 1},  '{0, 0, 0, 1}
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a[5:0]; wr_data = d[15:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Start from idle; count samples until seq_end is seen.
    task automatic play(output int cyc, output int hi);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        cyc = 0; hi = 0;
        while (!seq_end && cyc < 5000) begin
            cyc++; hi += int'(pwm_out);
            @(negedge clk);
        end
    endtask

    // From a seq_end sample, count one looped pass up to the next seq_end.
    task automatic pass(input bit poke, output int cyc, output int hi);
        cyc = 0; hi = 0;
        do begin
            cyc++; hi += int'(pwm_out);
            start = (poke && cyc == 3);
            @(negedge clk);
        end while (!seq_end && cyc < 5000);
        start = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int cyc, hi, mult, ex_c, ex_h, tp;
        string rq;
        repeat (4) @(negedge clk);
        // R1 reset state
        check("R1", "pwm in reset", int'(pwm_out), 0);
        check("R1", "seq_end in reset", int'(seq_end), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R12", "idle pwm without start", int'(pwm_out), 0);

        // Vector table: single-step sequences, shared-period layout
        for (int i = 0; i < NV; i++) begin
            presc_sel = VEC[i][0][2:0];
            updown    = VEC[i][1][0];
            base_top  = VEC[i][2][15:0];
            wave_mode = 1'b0; loop_en = 1'b0; last_step = '0;
            wr(0, VEC[i][3]);
            play(cyc, hi);
            tp   = (VEC[i][2] == 0) ? 1 : VEC[i][2];
            mult = (1 << VEC[i][0]) * (VEC[i][1] ? 2 : 1);
            ex_c = tp * mult;
            ex_h = ((VEC[i][3] > tp) ? tp : VEC[i][3]) * mult;
            rq = VEC[i][1] ? "R4" : "R3";
            if (VEC[i][3] == 0 || VEC[i][3] >= tp) rq = "R5";
            if (VEC[i][2] == 0) rq = "R6";
            check((VEC[i][0] != 0) ? "R2" : rq, "period cycles", cyc, ex_c);
            check(rq, "high cycles", hi, ex_h);
        end
        // R10: pulse lasts one cycle
        @(negedge clk);
        check("R10", "seq_end width", int'(seq_end), 0);

        // R7: per-step layout; middle words are junk and must not matter
        presc_sel = 3'd0; updown = 1'b0; wave_mode = 1'b1; base_top = 16'd9;
        wr(0, 2); wr(1, 16'hFFFF); wr(2, 16'hFFFF); wr(3, 5);
        wr(4, 4); wr(5, 16'hFFFF); wr(6, 16'hFFFF); wr(7, 4);
        wr(8, 0); wr(9, 16'hFFFF); wr(10, 16'hFFFF); wr(11, 3);
        last_step = 6'd2;
        play(cyc, hi);
        check("R7", "per-step pass cycles", cyc, 12);
        check("R7", "per-step high cycles", hi, 6);

        // R8: eight-step table, prescaled
        wave_mode = 1'b0; presc_sel = 3'd1; base_top = 16'd4;
        wr(0, 2); wr(1, 3); wr(2, 4); wr(3, 3);
        wr(4, 2); wr(5, 1); wr(6, 0); wr(7, 1);
        last_step = 6'd7;
        play(cyc, hi);
        check("R8", "table pass cycles", cyc, 64);
        check("R8", "table high cycles", hi, 32);

        // R9: base_top changed mid-period
        presc_sel = 3'd0; base_top = 16'd8; last_step = '0;
        wr(0, 3);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        cyc = 0; hi = 0;
        while (!seq_end && cyc < 5000) begin
            cyc++; hi += int'(pwm_out);
            if (cyc == 2) base_top = 16'd20;
            @(negedge clk);
        end
        check("R9", "period after mid change", cyc, 8);
        check("R9", "high after mid change", hi, 3);

        // R11/R12: looping two-step table
        base_top = 16'd4; last_step = 6'd1; loop_en = 1'b1;
        wr(0, 1); wr(1, 3);
        play(cyc, hi);
        check("R8", "first loop pass cycles", cyc, 8);
        check("R8", "first loop pass highs", hi, 4);
        pass(1'b0, cyc, hi);
        check("R11", "wrap pass cycles", cyc, 8);
        check("R11", "wrap pass highs", hi, 4);
        pass(1'b1, cyc, hi);
        check("R12", "pass with start poke cycles", cyc, 8);
        check("R12", "pass with start poke highs", hi, 4);
        loop_en = 1'b0;
        pass(1'b0, cyc, hi);
        check("R11", "final pass cycles", cyc, 8);
        hi = 0; cyc = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            hi += int'(pwm_out); cyc += int'(seq_end);
        end
        check("R11", "pin after stop", hi, 0);
        check("R10", "seq_end after stop", cyc, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule